// File: doc/BRIEF.md
# Store Buffer with Atomic Ordering

This block sits between a core's store pipeline and a data cache that can execute read-modify-write operations itself. Plain stores and atomic memory operations enter one in-order queue and leave it for the cache strictly oldest first. An atomic is handled as a special kind of store, so it can only reach the cache once every store that entered before it has been accepted there.

Younger loads probe the queue through a lookup port and get one of three answers: the data comes from the queue (hit), the queue holds nothing for those bytes (miss), or the load has to wait. A load never takes data from a pending atomic, because the atomic's result only exists once the cache has run it. An atomic whose byte range would cross a cache line is refused when it is offered, and an error flag is raised in that same cycle.

Top module: `store_buffer_amo`

## Requirements
- R1: A valid enqueue is accepted when the queue is not full and no error is flagged. Accepted entries of either kind (enq_kind 0 = store, 1 = atomic) go to the cache in the order they arrived, with their address, size, data, byte mask and opcode unchanged.
- R2: creq_valid is high exactly when the queue holds at least one entry, and it presents the oldest entry. That entry is removed on the clock edge where creq_valid and creq_ready are both high. Until then, creq_valid and the request fields stay stable.
- R3: An atomic entry is presented on the cache port only once every entry that entered before it has been accepted by the cache.
- R4: full is high exactly when DEPTH entries are held. An enqueue offered while full is ignored, and no held entry is overwritten.
- R5: An atomic whose starting byte offset within its line (enq_addr modulo LINE_BYTES) plus 2^enq_size exceeds LINE_BYTES raises enq_err in the same cycle and is not stored. Stores never raise enq_err.
- R6: A load and an entry overlap when the load word address (ld_waddr) equals the entry's byte address with its low log2(DATA_W/8) bits dropped, and the two byte masks share a set bit. If the youngest overlapping entry is a store whose mask covers every byte of ld_mask, fwd_result is 1 (hit). fwd_data then carries that store's bytes on the load's byte lanes and zero on the other lanes.
- R7: If the youngest overlapping entry is an atomic, fwd_result is 2 (wait), even when an older store covers the load.
- R8: If the youngest overlapping entry is a store that covers only part of ld_mask, fwd_result is 2 (wait).
- R9: With no overlapping entry, or with ld_valid low, fwd_result is 0 (miss). Whenever the result is not a hit, fwd_data is zero.
- R10: fwd_result never takes the value 3.
- R11: After reset the queue is empty: full and creq_valid are low and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enq_valid | input | 1 | Enqueue offer |
| enq_kind | input | 1 | 0 = store, 1 = atomic |
| enq_addr | input | ADDR_W | Byte address |
| enq_size | input | SIZE_W | Access size as log2 of the byte count |
| enq_data | input | DATA_W | Store data or atomic operand |
| enq_mask | input | DATA_W/8 | Byte enables within the word |
| enq_amo_op | input | OP_W | Atomic opcode, passed through to the cache |
| full | output | 1 | Queue holds DEPTH entries |
| enq_err | output | 1 | Atomic refused because it crosses a line |
| ld_valid | input | 1 | Load lookup valid |
| ld_waddr | input | ADDR_W-log2(DATA_W/8) | Load word address |
| ld_mask | input | DATA_W/8 | Load byte mask |
| fwd_result | output | 2 | 0 miss, 1 hit, 2 wait |
| fwd_data | output | DATA_W | Forwarded bytes on a hit |
| creq_valid | output | 1 | Cache request valid |
| creq_ready | input | 1 | Cache accepts the request |
| creq_kind | output | 1 | Kind of the head entry |
| creq_addr | output | ADDR_W | Byte address of the head entry |
| creq_size | output | SIZE_W | Size of the head entry |
| creq_data | output | DATA_W | Data of the head entry |
| creq_mask | output | DATA_W/8 | Byte mask of the head entry |
| creq_amo_op | output | OP_W | Atomic opcode of the head entry |

## Verification
The bench builds the block with a depth of four entries, 32-bit data, 16-byte lines and sizes of up to eight bytes. With only four entries, the queue fills within a few enqueues, so rejection while full and pointer wrap-around both come up often under random traffic. Sizes of up to eight bytes let an atomic starting at offsets 9 to 15 cross the 16-byte line, while offset 8 with eight bytes lands exactly on the boundary. Addresses are confined to a single line, so younger atomics, partial masks and several overlapping stores keep meeting the same words.

// File: rtl/sb_pkg.sv
package sb_pkg;
   typedef enum logic {
      SB_STORE  = 1'b0,
      SB_ATOMIC = 1'b1
   } sb_kind_e;

   typedef enum logic [1:0] {
      FWD_MISS = 2'd0,
      FWD_HIT  = 2'd1,
      FWD_WAIT = 2'd2
   } sb_fwd_e;
endpackage

// File: rtl/sb_line_check.sv
module sb_line_check #(
   parameter int SIZE_W     = 2,
   parameter int LINE_BYTES = 16,
   parameter int LOFF_W     = $clog2(LINE_BYTES)
) (
   input  logic [LOFF_W-1:0] line_off,
   input  logic [SIZE_W-1:0] size,
   input  logic              is_atomic,
   output logic              crosses
);
   logic [31:0] off_ext;
   logic [31:0] span;

   assign off_ext = 32'(line_off);
   assign span    = 32'd1 << size;
   assign crosses = is_atomic && ((off_ext + span) > 32'(LINE_BYTES));
endmodule

// File: rtl/sb_queue.sv
module sb_queue #(
   parameter int DEPTH  = 4,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int OP_W   = 4,
   parameter int SIZE_W = 2,
   parameter int BYTES  = DATA_W / 8,
   parameter int WOFF   = $clog2(BYTES),
   parameter int PTR_W  = $clog2(DEPTH),
   parameter int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               push,
   input  logic                               pop,
   input  logic                               in_kind,
   input  logic [ADDR_W-1:0]                  in_addr,
   input  logic [SIZE_W-1:0]                  in_size,
   input  logic [DATA_W-1:0]                  in_data,
   input  logic [BYTES-1:0]                   in_mask,
   input  logic [OP_W-1:0]                    in_op,
   output logic [PTR_W-1:0]                   rd_ptr,
   output logic [CNT_W-1:0]                   count,
   output logic [DEPTH-1:0]                   kind_q,
   output logic [DEPTH-1:0][ADDR_W-1:0]       addr_q,
   output logic [DEPTH-1:0][ADDR_W-WOFF-1:0]  waddr_q,
   output logic [DEPTH-1:0][SIZE_W-1:0]       size_q,
   output logic [DEPTH-1:0][DATA_W-1:0]       data_q,
   output logic [DEPTH-1:0][BYTES-1:0]        mask_q,
   output logic [DEPTH-1:0][OP_W-1:0]         op_q
);
   logic [PTR_W-1:0] wr_ptr;

   function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (push) begin
         kind_q[wr_ptr] <= in_kind;
         addr_q[wr_ptr] <= in_addr;
         size_q[wr_ptr] <= in_size;
         data_q[wr_ptr] <= in_data;
         mask_q[wr_ptr] <= in_mask;
         op_q[wr_ptr]   <= in_op;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= step_ptr(wr_ptr);
         if (pop)  rd_ptr <= step_ptr(rd_ptr);
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   for (genvar s = 0; s < DEPTH; s++) begin : g_waddr
      assign waddr_q[s] = addr_q[s][ADDR_W-1:WOFF];
   end

   assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (count < CNT_W'(DEPTH)));

   assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (count != '0));
endmodule

// File: rtl/sb_fwd.sv
module sb_fwd
   import sb_pkg::*;
#(
   parameter int DEPTH  = 4,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int BYTES  = DATA_W / 8,
   parameter int WOFF   = $clog2(BYTES),
   parameter int PTR_W  = $clog2(DEPTH),
   parameter int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic [PTR_W-1:0]                  rd_ptr,
   input  logic [CNT_W-1:0]                  count,
   input  logic [DEPTH-1:0]                  kind_q,
   input  logic [DEPTH-1:0][ADDR_W-WOFF-1:0] waddr_q,
   input  logic [DEPTH-1:0][DATA_W-1:0]      data_q,
   input  logic [DEPTH-1:0][BYTES-1:0]       mask_q,
   input  logic                              ld_valid,
   input  logic [ADDR_W-WOFF-1:0]            ld_waddr,
   input  logic [BYTES-1:0]                  ld_mask,
   output sb_fwd_e                           result,
   output logic [DATA_W-1:0]                 data
);
   logic [DATA_W-1:0] lane_bits;

   for (genvar b = 0; b < BYTES; b++) begin : g_lane
      assign lane_bits[b*8 +: 8] = {8{ld_mask[b]}};
   end

   // Walk from oldest to youngest; the last overlapping entry decides.
   always_comb begin
      int               slot;
      logic [PTR_W-1:0] s;
      result = FWD_MISS;
      data   = '0;
      for (int i = 0; i < DEPTH; i++) begin
         slot = int'(rd_ptr) + i;
         if (slot >= DEPTH) slot = slot - DEPTH;
         s = PTR_W'(slot);
         if (ld_valid && (i < int'(count)) && (waddr_q[s] == ld_waddr) &&
             ((mask_q[s] & ld_mask) != '0)) begin
            if (sb_kind_e'(kind_q[s]) == SB_ATOMIC) begin
               result = FWD_WAIT;
               data   = '0;
            end else if ((ld_mask & ~mask_q[s]) == '0) begin
               result = FWD_HIT;
               data   = data_q[s] & lane_bits;
            end else begin
               result = FWD_WAIT;
               data   = '0;
            end
         end
      end
   end
endmodule

// File: rtl/store_buffer_amo.sv
module store_buffer_amo
   import sb_pkg::*;
#(
   parameter int DEPTH      = 4,
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 32,
   parameter int OP_W       = 4,
   parameter int SIZE_W     = 2,
   parameter int LINE_BYTES = 16
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic                                     enq_valid,
   input  logic                                     enq_kind,
   input  logic [ADDR_W-1:0]                        enq_addr,
   input  logic [SIZE_W-1:0]                        enq_size,
   input  logic [DATA_W-1:0]                        enq_data,
   input  logic [DATA_W/8-1:0]                      enq_mask,
   input  logic [OP_W-1:0]                          enq_amo_op,
   output logic                                     full,
   output logic                                     enq_err,
   input  logic                                     ld_valid,
   input  logic [ADDR_W-$clog2(DATA_W/8)-1:0]       ld_waddr,
   input  logic [DATA_W/8-1:0]                      ld_mask,
   output logic [1:0]                               fwd_result,
   output logic [DATA_W-1:0]                        fwd_data,
   output logic                                     creq_valid,
   input  logic                                     creq_ready,
   output logic                                     creq_kind,
   output logic [ADDR_W-1:0]                        creq_addr,
   output logic [SIZE_W-1:0]                        creq_size,
   output logic [DATA_W-1:0]                        creq_data,
   output logic [DATA_W/8-1:0]                      creq_mask,
   output logic [OP_W-1:0]                          creq_amo_op
);
   localparam int BYTES  = DATA_W / 8;
   localparam int WOFF   = $clog2(BYTES);
   localparam int PTR_W  = $clog2(DEPTH);
   localparam int CNT_W  = $clog2(DEPTH + 1);
   localparam int LOFF_W = $clog2(LINE_BYTES);

   if (DEPTH < 2) begin : g_chk_depth
      $error("store_buffer_amo: DEPTH must be at least 2");
   end
   if ((DATA_W % 8) != 0 || DATA_W < 8) begin : g_chk_data
      $error("store_buffer_amo: DATA_W must be a whole number of bytes");
   end
   if ((1 << LOFF_W) != LINE_BYTES || LINE_BYTES < BYTES) begin : g_chk_line
      $error("store_buffer_amo: LINE_BYTES must be a power of two of at least one word");
   end

   logic                              push, pop, crosses;
   logic [PTR_W-1:0]                  q_rd_ptr;
   logic [CNT_W-1:0]                  q_count;
   logic [DEPTH-1:0]                  kind_q;
   logic [DEPTH-1:0][ADDR_W-1:0]      addr_q;
   logic [DEPTH-1:0][ADDR_W-WOFF-1:0] waddr_q;
   logic [DEPTH-1:0][SIZE_W-1:0]      size_q;
   logic [DEPTH-1:0][DATA_W-1:0]      data_q;
   logic [DEPTH-1:0][BYTES-1:0]       mask_q;
   logic [DEPTH-1:0][OP_W-1:0]        op_q;
   sb_fwd_e                           fwd_res;

   sb_line_check #(
      .SIZE_W(SIZE_W), .LINE_BYTES(LINE_BYTES)
   ) i_line_check (
      .line_off(enq_addr[LOFF_W-1:0]), .size(enq_size),
      .is_atomic(enq_kind == SB_ATOMIC), .crosses(crosses)
   );

   assign full       = (q_count == CNT_W'(DEPTH));
   assign enq_err    = enq_valid && crosses;
   assign push       = enq_valid && !full && !crosses;
   assign creq_valid = (q_count != '0);
   assign pop        = creq_valid && creq_ready;

   sb_queue #(
      .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OP_W(OP_W), .SIZE_W(SIZE_W)
   ) i_queue (
      .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
      .in_kind(enq_kind), .in_addr(enq_addr), .in_size(enq_size),
      .in_data(enq_data), .in_mask(enq_mask), .in_op(enq_amo_op),
      .rd_ptr(q_rd_ptr), .count(q_count), .kind_q(kind_q), .addr_q(addr_q),
      .waddr_q(waddr_q), .size_q(size_q), .data_q(data_q), .mask_q(mask_q), .op_q(op_q)
   );

   assign creq_kind   = kind_q[q_rd_ptr];
   assign creq_addr   = addr_q[q_rd_ptr];
   assign creq_size   = size_q[q_rd_ptr];
   assign creq_data   = data_q[q_rd_ptr];
   assign creq_mask   = mask_q[q_rd_ptr];
   assign creq_amo_op = op_q[q_rd_ptr];

   sb_fwd #(
      .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) i_fwd (
      .rd_ptr(q_rd_ptr), .count(q_count), .kind_q(kind_q), .waddr_q(waddr_q),
      .data_q(data_q), .mask_q(mask_q), .ld_valid(ld_valid), .ld_waddr(ld_waddr),
      .ld_mask(ld_mask), .result(fwd_res), .data(fwd_data)
   );

   assign fwd_result = fwd_res;

   assert_hold_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (creq_valid && !creq_ready) |=> (creq_valid && $stable(creq_addr) &&
                                       $stable(creq_data) && $stable(creq_kind)));

   assert_refused_not_stored_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (enq_err && !pop) |=> (q_count == $past(q_count)));

   assert_full_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !pop) |=> (q_count == $past(q_count)));

   assert_result_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_result != 2'd3);

   assert_nonhit_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_result != 2'd1) |-> (fwd_data == '0));
endmodule

// File: tb/test_store_buffer_amo.sv
module test_store_buffer_amo;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 4;
   localparam int ADDR_W     = 16;
   localparam int DATA_W     = 32;
   localparam int OP_W       = 4;
   localparam int SIZE_W     = 2;
   localparam int LINE_BYTES = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              enq_valid = 1'b0, enq_kind = 1'b0;
   logic [15:0]       enq_addr = '0;
   logic [1:0]        enq_size = '0;
   logic [31:0]       enq_data = '0;
   logic [3:0]        enq_mask = '0;
   logic [3:0]        enq_amo_op = '0;
   logic              full, enq_err;
   logic              ld_valid = 1'b0;
   logic [13:0]       ld_waddr = '0;
   logic [3:0]        ld_mask = '0;
   logic [1:0]        fwd_result;
   logic [31:0]       fwd_data;
   logic              creq_valid, creq_ready = 1'b0, creq_kind;
   logic [15:0]       creq_addr;
   logic [1:0]        creq_size;
   logic [31:0]       creq_data;
   logic [3:0]        creq_mask;
   logic [3:0]        creq_amo_op;

   store_buffer_amo #(
      .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OP_W(OP_W),
      .SIZE_W(SIZE_W), .LINE_BYTES(LINE_BYTES)
   ) i_store_buffer_amo (
      .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_kind(enq_kind),
      .enq_addr(enq_addr), .enq_size(enq_size), .enq_data(enq_data),
      .enq_mask(enq_mask), .enq_amo_op(enq_amo_op), .full(full), .enq_err(enq_err),
      .ld_valid(ld_valid), .ld_waddr(ld_waddr), .ld_mask(ld_mask),
      .fwd_result(fwd_result), .fwd_data(fwd_data), .creq_valid(creq_valid),
      .creq_ready(creq_ready), .creq_kind(creq_kind), .creq_addr(creq_addr),
      .creq_size(creq_size), .creq_data(creq_data), .creq_mask(creq_mask),
      .creq_amo_op(creq_amo_op)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct packed {
      logic        kind;
      logic [15:0] addr;
      logic [1:0]  size;
      logic [31:0] data;
      logic [3:0]  mask;
      logic [3:0]  op;
   } ent_t;

   ent_t mq[$];
   int   checks = 0;
   int   fails  = 0;

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic logic exp_cross(input logic kind, input logic [15:0] a,
                                      input logic [1:0] sz);
      int off;
      off = int'(a) % LINE_BYTES;
      return kind && ((off + (1 << sz)) > LINE_BYTES);
   endfunction

   // Behavioural forwarding rule: youngest overlapping entry decides.
   task automatic exp_fwd(output logic [1:0] r, output logic [31:0] d);
      r = 2'd0;
      d = '0;
      if (ld_valid) begin
         foreach (mq[i]) begin
            if (mq[i].addr[15:2] == ld_waddr && (mq[i].mask & ld_mask) != 4'b0) begin
               d = '0;
               if (mq[i].kind) r = 2'd2;
               else if ((ld_mask & ~mq[i].mask) == 4'b0) begin
                  r = 2'd1;
                  for (int b = 0; b < 4; b++)
                     if (ld_mask[b]) d[b*8 +: 8] = mq[i].data[b*8 +: 8];
               end else r = 2'd2;
            end
         end
      end
   endtask

   task automatic step();
      logic       e_full, e_err, acc, do_pop;
      logic [1:0] e_r;
      logic [31:0] e_d;
      string      tag;
      ent_t       ne;
      #2;
      e_full = (mq.size() == DEPTH);
      e_err  = enq_valid && exp_cross(enq_kind, enq_addr, enq_size);
      acc    = enq_valid && !e_full && !e_err;
      chk("R4", "full", 64'(full), 64'(e_full));
      chk("R5", "enq_err", 64'(enq_err), 64'(e_err));
      chk("R2", "creq_valid", 64'(creq_valid), 64'(mq.size() != 0));
      if (mq.size() != 0) begin
         tag = mq[0].kind ? "R3" : "R1";
         chk(tag, "creq_kind", 64'(creq_kind), 64'(mq[0].kind));
         chk(tag, "creq_addr", 64'(creq_addr), 64'(mq[0].addr));
         chk(tag, "creq_size", 64'(creq_size), 64'(mq[0].size));
         chk(tag, "creq_data", 64'(creq_data), 64'(mq[0].data));
         chk(tag, "creq_mask", 64'(creq_mask), 64'(mq[0].mask));
         chk(tag, "creq_amo_op", 64'(creq_amo_op), 64'(mq[0].op));
      end
      exp_fwd(e_r, e_d);
      case (e_r)
         2'd1:    tag = "R6/R10";
         2'd2:    tag = "R7/R8";
         default: tag = "R9";
      endcase
      chk(tag, "fwd_result", 64'(fwd_result), 64'(e_r));
      chk(tag, "fwd_data", 64'(fwd_data), 64'(e_d));
      do_pop = (mq.size() != 0) && creq_ready;
      ne = '{enq_kind, enq_addr, enq_size, enq_data, enq_mask, enq_amo_op};
      @(posedge clk);
      if (do_pop) void'(mq.pop_front());
      if (acc) mq.push_back(ne);
      @(negedge clk);
   endtask

   task automatic enq(input logic k, input logic [15:0] a, input logic [1:0] sz,
                      input logic [31:0] d, input logic [3:0] m);
      enq_valid = 1'b1; enq_kind = k; enq_addr = a; enq_size = sz;
      enq_data = d; enq_mask = m; enq_amo_op = k ? 4'h5 : 4'h0;
      step();
      enq_valid = 1'b0;
   endtask

   task automatic look(input logic [13:0] w, input logic [3:0] m);
      ld_valid = 1'b1; ld_waddr = w; ld_mask = m;
      step();
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      ld_valid = 1'b1; ld_waddr = 14'h10; ld_mask = 4'hF;
      #2;
      chk("R11", "full after reset", 64'(full), 64'd0);
      chk("R11", "creq_valid after reset", 64'(creq_valid), 64'd0);
      chk("R11", "lookup after reset", 64'(fwd_result), 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R6: full cover hit, R9: other word misses
      enq(1'b0, 16'h0040, 2'd2, 32'hA1A2A3A4, 4'hF);
      look(14'h10, 4'h3);
      look(14'h11, 4'h1);
      // R8: younger half store gives partial wait; upper bytes hit older store
      enq(1'b0, 16'h0040, 2'd1, 32'hB1B2B3B4, 4'h3);
      look(14'h10, 4'h3);
      look(14'h10, 4'hF);
      look(14'h10, 4'hC);
      // R7: atomic youngest gives wait
      enq(1'b1, 16'h0044, 2'd2, 32'h00000007, 4'hF);
      look(14'h11, 4'hF);
      // R6: store after the atomic fills the queue and forwards
      enq(1'b0, 16'h0044, 2'd2, 32'hC1C2C3C4, 4'hF);
      look(14'h11, 4'hF);
      // R4: enqueue while full is dropped
      enq(1'b0, 16'h0048, 2'd2, 32'hDEADBEEF, 4'hF);
      // R5: crossing atomic flagged even while full
      enq(1'b1, 16'h004C, 2'd3, 32'h1, 4'hF);
      ld_valid = 1'b0;
      step();
      // R1, R2, R3: drain in order with the cache ready
      creq_ready = 1'b1;
      repeat (5) step();
      creq_ready = 1'b0;
      // R5 boundaries
      enq(1'b1, 16'h0048, 2'd3, 32'h2, 4'hF);
      enq(1'b1, 16'h004F, 2'd0, 32'h3, 4'h8);
      enq(1'b1, 16'h004F, 2'd1, 32'h4, 4'h8);
      enq(1'b0, 16'h004F, 2'd3, 32'h5, 4'h8);
      step();
      creq_ready = 1'b1;
      repeat (5) step();

      // Random traffic on one line
      for (int n = 0; n < 600; n++) begin
         enq_valid  = ($urandom % 3) != 0;
         enq_kind   = ($urandom % 4) == 0;
         enq_addr   = 16'h0040 + 16'($urandom % 16);
         enq_size   = 2'($urandom);
         enq_data   = $urandom;
         enq_mask   = 4'($urandom);
         enq_amo_op = 4'($urandom);
         ld_valid   = ($urandom % 4) != 0;
         ld_waddr   = 14'h10 + 14'($urandom % 4);
         ld_mask    = 4'($urandom);
         creq_ready = ($urandom % 3) == 0;
         step();
      end
      enq_valid = 1'b0;
      creq_ready = 1'b1;
      repeat (6) step();

      summary();
      $finish;
   end
endmodule